// File: doc/BRIEF.md
# Byte-Wide One-Time-Clearable Memory Core with Mode Control

This block is a synthesizable behavioural model of a byte-wide, ultraviolet-erasable read-only memory. Five control inputs (chip select, output gate, program strobe, programming-supply-present flag and identification-voltage flag) are decoded into seven operating modes. The modes are read, output disable, standby, program, program verify, program inhibit and identification. A host reads bytes through an 8-bit output bus that carries a separate drive-enable for an external tristate buffer. A programmer writes bytes through a separate 8-bit input bus.

Programming is one-directional. A write can only clear bits, so the stored byte becomes the old byte ANDed with the offered byte. Only the bulk-erase input, which sets every bit to one, restores ones. When a write occurs is defined by the clock. A write happens once for each high-to-low transition of the program strobe seen at a rising clock edge while program conditions hold. The address port is 17 bits wide. The stored array holds 2^`MEM_AW` bytes, and address bits above that width alias.

Top module: `emc_eprom`

## Requirements
- R1: With ce_n=0, oe_n=0 and a9_hv=0, data_oe is 1 and data_out shows the byte stored at the current address in the same cycle.
- R2: With ce_n=1 and vpp_hi=0, data_oe is 0 and data_out is 8'h00 whatever oe_n is. This also holds during reset.
- R3: With ce_n=0 and oe_n=1, data_oe is 0 and data_out is 8'h00. A strobe pulse while vpp_hi=0 writes nothing.
- R4: With ce_n=0, oe_n=1 and vpp_hi=1, a rising clock edge at which pgm_n is 0, after being 1 at the previous rising edge, writes to the addressed byte. A pgm_n already low when vpp_hi rises does not write.
- R5: A write stores old_byte & data_in. Bits that are 0 stay 0.
- R6: Holding pgm_n low after a write causes no further write, even if data_in changes.
- R7: With ce_n=0, oe_n=0, vpp_hi=1 and pgm_n=1 (verify), the addressed byte is driven out.
- R8: With ce_n=1 and vpp_hi=1 (inhibit), strobe pulses write nothing and data_oe is 0.
- R9: With a9_hv=1, ce_n=0 and oe_n=0, the output is 8'h8F when addr[0]=0 and 8'h86 when addr[0]=1.
- R10: During a read, pgm_n and vpp_hi do not change data_out.
- R11: erase high at a rising edge sets every byte to 8'hFF at that edge. It overrides a write due at the same edge.
- R12: Address bits at and above MEM_AW (default 11) are ignored by the array, so addresses that differ only in those bits select the same byte.
- R13: A pgm_n that is already low when reset releases does not produce a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase | input | 1 | Synchronous bulk erase to all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | Identification voltage present |
| addr | input | 17 | Byte address |
| data_in | input | 8 | Byte offered for programming |
| data_out | output | 8 | Byte driven to the bus, zero when not driven |
| data_oe | output | 1 | Bus drive enable |

## Verification
A wrong stored cell stays hidden until that exact address is read back, so every write in the bench is followed by a read of the written address and of a neighbouring address. A fault in the strobe edge detector shows as a missing write, or as an extra write that clears bits a later data_in should not have touched. That second effect is visible one cycle after the edge. Mode decode faults show in the same cycle as a wrong data_oe, or as identification codes or stored bytes appearing in the wrong mode.

// File: rtl/emc_pkg.sv
package emc_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_OUT_DIS,
    MD_READ,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_IDENT
  } mode_t;
endpackage

// File: rtl/emc_mode_dec.sv
module emc_mode_dec
  import emc_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  output mode_t mode
);
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (!oe_n) begin
      if (a9_hv)                mode = MD_IDENT;
      else if (vpp_hi && pgm_n) mode = MD_VERIFY;
      else                      mode = MD_READ;
    end else begin
      mode = (vpp_hi && !pgm_n) ? MD_PROG : MD_OUT_DIS;
    end
  end
endmodule

// File: rtl/emc_pgm_edge.sv
module emc_pgm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  input  logic prog_mode,
  output logic wr_stb
);
  logic pgm_q, pgm_d;

  always_comb begin
    pgm_d  = pgm_n;
    wr_stb = prog_mode && pgm_q && !pgm_n;
  end

  // pgm_q resets low, so a strobe that is already low at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b0;
    else        pgm_q <= pgm_d;
  end

  // R6: a strobe can never fire on two consecutive edges
  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/emc_array.sv
module emc_array #(
  parameter int MEM_AW = 11,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] cells [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] cell_q, cell_d;
      logic          cell_en;
      always_comb begin
        cell_en = erase || (wr_en && (idx == MEM_AW'(g)));
        cell_d  = erase ? {DW{1'b1}} : (cell_q & wdata);
      end
      always_ff @(posedge clk) begin
        if (cell_en) cell_q <= cell_d;
      end
      assign cells[g] = cell_q;
    end
  endgenerate

  assign rdata = cells[idx];

  // R5: a write only clears bits
  assert_and_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> cells[$past(idx)] == ($past(rdata) & $past(wdata)));
  // R11: erase sets the addressed cell to all ones
  assert_erase_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> cells[$past(idx)] == {DW{1'b1}});
  // R3: without a strobe or erase the addressed cell keeps its value
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !erase) |=> cells[$past(idx)] == $past(rdata));
endmodule

// File: rtl/emc_out_mux.sv
module emc_out_mux
  import emc_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] MFR_CODE = 8'h8F,
  parameter logic [DW-1:0] DEV_CODE = 8'h86
) (
  input  mode_t         mode,
  input  logic          sel0,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout,
  output logic          doe
);
  always_comb begin
    dout = '0;
    doe  = 1'b0;
    unique case (mode)
      MD_READ, MD_VERIFY: begin
        dout = rdata;
        doe  = 1'b1;
      end
      MD_IDENT: begin
        dout = sel0 ? DEV_CODE : MFR_CODE;
        doe  = 1'b1;
      end
      default: begin
        dout = '0;
        doe  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/emc_eprom.sv
module emc_eprom
  import emc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 11,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data_in,
  output logic [DW-1:0]     data_out,
  output logic              data_oe
);
  logic          rst_s1, rst_s2;
  mode_t         mode;
  logic          wr_stb;
  logic [DW-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  generate
    if (MEM_AW < ADDR_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:MEM_AW];
    end
  endgenerate

  emc_mode_dec u_dec (
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .pgm_n (pgm_n),
    .vpp_hi(vpp_hi),
    .a9_hv (a9_hv),
    .mode  (mode)
  );

  emc_pgm_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_s2),
    .pgm_n    (pgm_n),
    .prog_mode(mode == MD_PROG),
    .wr_stb   (wr_stb)
  );

  emc_array #(.MEM_AW(MEM_AW), .DW(DW)) u_arr (
    .clk  (clk),
    .rst_n(rst_s2),
    .erase(erase),
    .wr_en(wr_stb),
    .idx  (addr[MEM_AW-1:0]),
    .wdata(data_in),
    .rdata(rdata)
  );

  emc_out_mux #(.DW(DW)) u_mux (
    .mode (mode),
    .sel0 (addr[0]),
    .rdata(rdata),
    .dout (data_out),
    .doe  (data_oe)
  );

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_s2)
    (!ce_n && !oe_n) |-> data_oe);
  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_s2)
    (ce_n && !vpp_hi) |-> (!data_oe && data_out == '0));
  assert_outdis_quiet_R3: assert property (@(posedge clk) disable iff (!rst_s2)
    (!ce_n && oe_n) |-> !data_oe);
  assert_inhibit_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_s2)
    ce_n |-> !wr_stb);
endmodule

// File: tb/sim_emc_eprom.sv
`timescale 1ns/1ps
module sim_emc_eprom;
  logic        clk = 1'b0;
  logic        rst_n, erase, ce_n, oe_n, pgm_n, vpp_hi, a9_hv;
  logic [16:0] addr;
  logic [7:0]  data_in, data_out;
  logic        data_oe;
  int          checks = 0;
  int          failures = 0;

  always #2.5 clk = ~clk;

  emc_eprom u0 (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hv = 0; erase = 0;
  endtask

  task automatic rd(logic [16:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 0; a9_hv = 0; addr = a;
    #1;
    chk(req, {7'b0, data_oe}, 8'h01);
    chk(req, data_out, exp);
  endtask

  task automatic prog(logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = 0; oe_n = 1; pgm_n = 1; vpp_hi = 1; a9_hv = 0; addr = a; data_in = d;
    @(negedge clk); pgm_n = 0;
    @(negedge clk); pgm_n = 1;
    @(negedge clk); idle();
  endtask

  task automatic do_erase();
    @(negedge clk); erase = 1;
    @(negedge clk); erase = 0;
  endtask

  task automatic t_reset();
    idle(); rst_n = 0; addr = '0; data_in = '0; oe_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset oe", {7'b0, data_oe}, 8'h00);
    chk("R2 reset data", data_out, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_erase();
    do_erase();
    rd(17'd0, 8'hFF, "R11 erase a0");
    rd(17'd5, 8'hFF, "R11 erase a5");
    rd(17'd2047, 8'hFF, "R1 R11 erase top");
  endtask

  task automatic t_program();
    prog(17'd5, 8'hA5);
    rd(17'd5, 8'hA5, "R4 write");
    prog(17'd5, 8'h0F);
    rd(17'd5, 8'h05, "R5 and");
    prog(17'd9, 8'h3C);
    rd(17'd9, 8'h3C, "R4 second addr");
    rd(17'd8, 8'hFF, "R1 neighbour");
  endtask

  task automatic t_outdis();
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp_hi = 0; pgm_n = 1; addr = 17'd7; data_in = 8'h00; #1;
    chk("R3 oe", {7'b0, data_oe}, 8'h00);
    chk("R3 data", data_out, 8'h00);
    @(negedge clk); pgm_n = 0;
    @(negedge clk); pgm_n = 1;
    @(negedge clk); idle();
    rd(17'd7, 8'hFF, "R3 no write");
  endtask

  task automatic t_standby();
    @(negedge clk);
    idle(); oe_n = 0; addr = 17'd5; #1;
    chk("R2 standby oe", {7'b0, data_oe}, 8'h00);
    chk("R2 standby data", data_out, 8'h00);
  endtask

  task automatic t_inhibit();
    @(negedge clk);
    ce_n = 1; oe_n = 1; vpp_hi = 1; pgm_n = 1; addr = 17'd7; data_in = 8'h00;
    @(negedge clk); pgm_n = 0; #1;
    chk("R8 oe", {7'b0, data_oe}, 8'h00);
    @(negedge clk); pgm_n = 1;
    @(negedge clk); idle();
    rd(17'd7, 8'hFF, "R8 no write");
  endtask

  task automatic t_verify();
    @(negedge clk);
    ce_n = 0; oe_n = 0; vpp_hi = 1; pgm_n = 1; a9_hv = 0; addr = 17'd5; #1;
    chk("R7 oe", {7'b0, data_oe}, 8'h01);
    chk("R7 data", data_out, 8'h05);
    @(negedge clk); idle();
  endtask

  task automatic t_ident();
    @(negedge clk);
    ce_n = 0; oe_n = 0; a9_hv = 1; addr = 17'd0; #1;
    chk("R9 mfr", data_out, 8'h8F);
    @(negedge clk); addr = 17'd1; #1;
    chk("R9 dev", data_out, 8'h86);
    @(negedge clk); addr = 17'd5; #1;
    chk("R9 odd", data_out, 8'h86);
    @(negedge clk); idle();
  endtask

  task automatic t_dontcare();
    @(negedge clk);
    ce_n = 0; oe_n = 0; a9_hv = 0; addr = 17'd5; pgm_n = 0; vpp_hi = 0; #1;
    chk("R10 pgm low", data_out, 8'h05);
    @(negedge clk); vpp_hi = 1; #1;
    chk("R10 vpp high", data_out, 8'h05);
    @(negedge clk); idle();
    rd(17'd5, 8'h05, "R10 unchanged");
  endtask

  task automatic t_hold();
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp_hi = 1; pgm_n = 1; addr = 17'd12; data_in = 8'hF0;
    @(negedge clk); pgm_n = 0;
    @(negedge clk); data_in = 8'h0F;
    repeat (3) @(negedge clk);
    pgm_n = 1;
    @(negedge clk); idle();
    rd(17'd12, 8'hF0, "R6 held low");
  endtask

  task automatic t_late_vpp();
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp_hi = 0; pgm_n = 1; addr = 17'd13; data_in = 8'h00;
    @(negedge clk); pgm_n = 0;
    @(negedge clk); vpp_hi = 1;
    repeat (2) @(negedge clk);
    pgm_n = 1;
    @(negedge clk); idle();
    rd(17'd13, 8'hFF, "R4 no edge");
  endtask

  task automatic t_erase_prio();
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp_hi = 1; pgm_n = 1; addr = 17'd20; data_in = 8'h00;
    @(negedge clk); pgm_n = 0; erase = 1;
    @(negedge clk); erase = 0; pgm_n = 1;
    @(negedge clk); idle();
    rd(17'd20, 8'hFF, "R11 priority");
    rd(17'd5, 8'hFF, "R11 all");
  endtask

  task automatic t_alias();
    prog(17'h00803, 8'h5A);
    rd(17'd3, 8'h5A, "R12 alias low");
    rd(17'h10003, 8'h5A, "R12 alias high");
  endtask

  task automatic t_reset_pgm();
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp_hi = 1; pgm_n = 0; addr = 17'd30; data_in = 8'h00;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    pgm_n = 1; idle();
    rd(17'd30, 8'hFF, "R13 no write");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_erase();
    t_program();
    t_outdis();
    t_standby();
    t_inhibit();
    t_verify();
    t_ident();
    t_dontcare();
    t_hold();
    t_late_vpp();
    t_erase_prio();
    t_alias();
    t_reset_pgm();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule